// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and a slower lower-level memory. Every store the processor issues is handed to the buffer instead of waiting on memory. The buffer keeps a small ring of block-sized entries. Each entry holds one aligned block, a mask of the words written so far, and the data of those words. A store to a block that already has an open entry is folded into that entry. A store to any other block opens a new entry. Entries leave one at a time, oldest first, as a single block-wide transfer that carries a per-word valid mask.

A mode input switches merging off. In that mode every store opens its own entry. This makes it easy to compare transfer counts between the two policies with identical traffic.

The head entry does not leave as soon as it appears. It is offered to memory once it is complete, once a younger entry waits behind it, or once it has gone unchanged for a fixed number of cycles. A burst of stores to one block therefore leaves as a single transfer. From the moment the head is offered, it is locked against further merges. A read-check port lets loads see data that is still in flight.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `wr_ready` is 1, `dr_valid` is 0 and `rc_hit` is 0.
- R2: With `merge_en` = 1, an accepted store whose block matches an open entry that is not being offered to memory updates that entry and opens no new one, so the words leave in one transfer.
- R3: With `merge_en` = 0, every accepted store opens its own entry, so N stores produce N transfers.
- R4: With `merge_en` = 1, 16 stores to consecutive word addresses starting on a block boundary produce exactly 4 transfers.
- R5: `wr_ready` is 0 only when all entries are occupied and the store cannot merge. It returns to 1 in the cycle after a transfer completes. A store that can merge into a full buffer is accepted.
- R6: Entries are offered in the order they were opened.
- R7: A transfer carries the block address on `dr_blk` (word address with the low log2(WORDS) bits removed). Word w sits at `dr_data[w*DATA_W +: DATA_W]`. `dr_mask[w]` is 1 exactly for the words written while the entry was open, and the mask is never zero.
- R8: When a word of an open entry is written twice, the later value is the one transferred.
- R9: `rc_hit` is 1 when the word at `rc_addr` is held in any entry. `rc_data` then gives the value from the youngest entry holding it.
- R10: Once `dr_valid` is 1, the offered entry takes no merges. `dr_valid`, `dr_blk` and `dr_mask` stay stable until `dr_ready` is seen. A store to that block opens a new entry.
- R11: The head entry is offered when its mask is full, or when a younger entry exists, or after exactly HOLD cycles without change. With HOLD = 8, a lone partial entry is offered on the 9th cycle after the store is accepted.
- R12: After any store sequence has fully drained, the memory image built from the transfers equals the image built directly from the accepted stores, with merging on or off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| merge_en | input | 1 | 1 folds stores into open entries, 0 gives each store its own entry |
| wr_valid | input | 1 | Store request |
| wr_ready | output | 1 | Store accepted when high with `wr_valid` |
| wr_addr | input | ADDR_W | Word address of the store |
| wr_data | input | DATA_W | Store data |
| dr_valid | output | 1 | Head entry offered to memory |
| dr_ready | input | 1 | Memory takes the offered entry |
| dr_blk | output | ADDR_W-log2(WORDS) | Block address of the offered entry |
| dr_mask | output | WORDS | Valid mask of the offered words |
| dr_data | output | WORDS*DATA_W | Block data, word w at bits w*DATA_W |
| rc_addr | input | ADDR_W | Word address to look up |
| rc_hit | output | 1 | Word is held in the buffer |
| rc_data | output | DATA_W | Held value (youngest copy), 0 on a miss |

## Verification
Corrupted entry state shows up at the ports in two ways. A wrong mask or a lost merge shows on `dr_mask` and `dr_data` at the next transfer. It also shows on `rc_hit` and `rc_data` in the very cycle the word is probed. A wrong ring pointer or occupancy count shows within one cycle as a wrong `wr_ready`, or as a block offered out of order. An age counter that drifts moves the rising edge of `dr_valid` by the same number of cycles. The reference model compares all of these on every clock, so a divergence is reported in the cycle it first appears rather than only in the final memory image.

// File: rtl/wb_pkg.sv
package wb_pkg;
    parameter int unsigned WB_ENTRIES = 4;
    parameter int unsigned WB_WORDS   = 4;
    parameter int unsigned WB_ADDR_W  = 16;
    parameter int unsigned WB_DATA_W  = 32;
    parameter int unsigned WB_HOLD    = 8;

    // why the head entry is (or is not) offered to memory
    typedef enum logic [1:0] {
        WHY_WAIT   = 2'd0,
        WHY_FULL   = 2'd1,
        WHY_BEHIND = 2'd2,
        WHY_AGED   = 2'd3
    } offer_why_e;
endpackage

// File: rtl/wb_tag_match.sv
module wb_tag_match #(
    parameter int unsigned N_ENT = 4,
    parameter int unsigned BLK_W = 14
) (
    input  logic [N_ENT-1:0]            ent_live,
    input  logic [N_ENT-1:0][BLK_W-1:0] ent_blk,
    input  logic [BLK_W-1:0]            probe_blk,
    output logic [N_ENT-1:0]            hit
);
    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        assign hit[i] = ent_live[i] && (ent_blk[i] == probe_blk);
    end
endmodule

// File: rtl/wb_ring_pick.sv
module wb_ring_pick #(
    parameter int unsigned N_ENT  = 4,
    parameter bit          NEWEST = 1'b0,
    localparam int unsigned PTR_W = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0] hit,
    input  logic [PTR_W-1:0] head,
    output logic             found,
    output logic [PTR_W-1:0] idx
);
    if (NEWEST) begin : g_newest
        // walk from head toward tail, the last hit seen is the youngest
        always_comb begin
            logic [PTR_W-1:0] pos;
            found = 1'b0;
            idx   = '0;
            for (int k = 0; k < N_ENT; k++) begin
                pos = head + PTR_W'(k);
                if (hit[pos]) begin
                    found = 1'b1;
                    idx   = pos;
                end
            end
        end
    end else begin : g_oldest
        // walk from tail toward head, the last hit seen is the oldest
        always_comb begin
            logic [PTR_W-1:0] pos;
            found = 1'b0;
            idx   = '0;
            for (int k = N_ENT - 1; k >= 0; k--) begin
                pos = head + PTR_W'(k);
                if (hit[pos]) begin
                    found = 1'b1;
                    idx   = pos;
                end
            end
        end
    end
endmodule

// File: rtl/wb_offer_ctl.sv
module wb_offer_ctl
    import wb_pkg::*;
#(
    parameter int unsigned N_WORDS = 4,
    parameter int unsigned HOLD    = 8,
    localparam int unsigned AGE_W  = $clog2(HOLD + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               head_live,
    input  logic [N_WORDS-1:0] head_mask,
    input  logic               deeper,
    input  logic               head_touched,
    input  logic               pop,
    output logic               offer
);
    typedef struct packed {
        logic [AGE_W-1:0] age;
    } age_st_t;

    age_st_t    st_d, st_q;
    offer_why_e why;

    // R11: complete, something waiting behind, or idle for HOLD cycles
    always_comb begin
        if (!head_live)                     why = WHY_WAIT;
        else if (&head_mask)                why = WHY_FULL;
        else if (deeper)                    why = WHY_BEHIND;
        else if (st_q.age == AGE_W'(HOLD))  why = WHY_AGED;
        else                                why = WHY_WAIT;
    end

    assign offer = (why != WHY_WAIT);

    always_comb begin
        st_d = st_q;
        if (pop || !head_live || head_touched)
            st_d.age = '0;
        else if (st_q.age != AGE_W'(HOLD))
            st_d.age = st_q.age + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf
    import wb_pkg::*;
#(
    parameter int unsigned N_ENT   = WB_ENTRIES,
    parameter int unsigned N_WORDS = WB_WORDS,
    parameter int unsigned ADDR_W  = WB_ADDR_W,
    parameter int unsigned DATA_W  = WB_DATA_W,
    parameter int unsigned HOLD    = WB_HOLD,
    localparam int unsigned OFF_W  = $clog2(N_WORDS),
    localparam int unsigned BLK_W  = ADDR_W - OFF_W,
    localparam int unsigned PTR_W  = $clog2(N_ENT),
    localparam int unsigned CNT_W  = $clog2(N_ENT + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      merge_en,
    input  logic                      wr_valid,
    output logic                      wr_ready,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    output logic                      dr_valid,
    input  logic                      dr_ready,
    output logic [BLK_W-1:0]          dr_blk,
    output logic [N_WORDS-1:0]        dr_mask,
    output logic [N_WORDS*DATA_W-1:0] dr_data,
    input  logic [ADDR_W-1:0]         rc_addr,
    output logic                      rc_hit,
    output logic [DATA_W-1:0]         rc_data
);
    // entries form a ring: opened at tail, retired at head (R6)
    typedef struct packed {
        logic                            live;
        logic [BLK_W-1:0]                blk;
        logic [N_WORDS-1:0]              mask;
        logic [N_WORDS-1:0][DATA_W-1:0]  data;
    } ent_t;

    typedef struct packed {
        ent_t [N_ENT-1:0]  ent;
        logic [PTR_W-1:0]  head;
        logic [PTR_W-1:0]  tail;
        logic [CNT_W-1:0]  cnt;
    } ring_t;

    ring_t st_d, st_q;

    logic [BLK_W-1:0]            wr_blk, rc_blk;
    logic [OFF_W-1:0]            wr_off, rc_off;
    logic [N_ENT-1:0]            e_live;
    logic [N_ENT-1:0][BLK_W-1:0] e_blk;
    logic [N_ENT-1:0]            w_hit, w_open, r_blkhit, r_wordhit;
    logic                        w_found, r_found;
    logic [PTR_W-1:0]            m_idx, r_idx;
    logic                        merge_hit, have_room, st_acc, alloc, pop;
    logic                        head_touched, deeper;
    logic [CNT_W-1:0]            cnt_now;

    assign wr_blk = wr_addr[ADDR_W-1:OFF_W];
    assign wr_off = wr_addr[OFF_W-1:0];
    assign rc_blk = rc_addr[ADDR_W-1:OFF_W];
    assign rc_off = rc_addr[OFF_W-1:0];

    always_comb begin
        for (int i = 0; i < N_ENT; i++) begin
            e_live[i] = st_q.ent[i].live;
            e_blk[i]  = st_q.ent[i].blk;
        end
    end

    // store-side block compare
    wb_tag_match #(.N_ENT(N_ENT), .BLK_W(BLK_W)) u_wmatch (
        .ent_live (e_live),
        .ent_blk  (e_blk),
        .probe_blk(wr_blk),
        .hit      (w_hit)
    );

    // R10: the offered head is closed to merges
    always_comb begin
        for (int i = 0; i < N_ENT; i++)
            w_open[i] = w_hit[i] && !(dr_valid && (st_q.head == PTR_W'(i)));
    end

    wb_ring_pick #(.N_ENT(N_ENT), .NEWEST(1'b0)) u_wpick (
        .hit  (w_open),
        .head (st_q.head),
        .found(w_found),
        .idx  (m_idx)
    );

    // R2 / R3: merging only when enabled
    assign merge_hit    = merge_en && w_found;
    assign have_room    = (st_q.cnt < CNT_W'(N_ENT));
    // R5
    assign wr_ready     = merge_hit || have_room;
    assign st_acc       = wr_valid && wr_ready;
    assign alloc        = st_acc && !merge_hit;
    assign pop          = dr_valid && dr_ready;
    assign head_touched = st_acc && merge_hit && (m_idx == st_q.head);
    assign deeper       = (st_q.cnt > CNT_W'(1));
    assign cnt_now      = st_q.cnt;

    wb_offer_ctl #(.N_WORDS(N_WORDS), .HOLD(HOLD)) u_offer (
        .clk         (clk),
        .rst_n       (rst_n),
        .head_live   (st_q.ent[st_q.head].live),
        .head_mask   (st_q.ent[st_q.head].mask),
        .deeper      (deeper),
        .head_touched(head_touched),
        .pop         (pop),
        .offer       (dr_valid)
    );

    // R7: drain port shows the head entry
    assign dr_blk  = st_q.ent[st_q.head].blk;
    assign dr_mask = st_q.ent[st_q.head].mask;
    assign dr_data = st_q.ent[st_q.head].data;

    // read-check side (R9)
    wb_tag_match #(.N_ENT(N_ENT), .BLK_W(BLK_W)) u_rmatch (
        .ent_live (e_live),
        .ent_blk  (e_blk),
        .probe_blk(rc_blk),
        .hit      (r_blkhit)
    );

    always_comb begin
        for (int i = 0; i < N_ENT; i++)
            r_wordhit[i] = r_blkhit[i] && st_q.ent[i].mask[rc_off];
    end

    wb_ring_pick #(.N_ENT(N_ENT), .NEWEST(1'b1)) u_rpick (
        .hit  (r_wordhit),
        .head (st_q.head),
        .found(r_found),
        .idx  (r_idx)
    );

    assign rc_hit  = r_found;
    assign rc_data = r_found ? st_q.ent[r_idx].data[rc_off] : '0;

    // next state
    always_comb begin
        ent_t nent;
        st_d = st_q;

        nent              = '0;
        nent.live         = 1'b1;
        nent.blk          = wr_blk;
        nent.mask[wr_off] = 1'b1;
        nent.data[wr_off] = wr_data;

        // R8: a repeated word simply overwrites
        if (st_acc && merge_hit) begin
            st_d.ent[m_idx].mask[wr_off] = 1'b1;
            st_d.ent[m_idx].data[wr_off] = wr_data;
        end

        if (alloc) begin
            st_d.ent[st_q.tail] = nent;
            st_d.tail           = st_q.tail + 1'b1;
        end

        if (pop) begin
            st_d.ent[st_q.head].live = 1'b0;
            st_d.ent[st_q.head].mask = '0;
            st_d.head                = st_q.head + 1'b1;
        end

        if (alloc && !pop)
            st_d.cnt = st_q.cnt + 1'b1;
        else if (!alloc && pop)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wb_chk.sv
module wb_chk #(
    parameter int unsigned BLK_W   = 14,
    parameter int unsigned N_WORDS = 4,
    parameter int unsigned CNT_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_valid,
    input logic               wr_ready,
    input logic               dr_valid,
    input logic               dr_ready,
    input logic [BLK_W-1:0]   dr_blk,
    input logic [N_WORDS-1:0] dr_mask,
    input logic               merge_hit,
    input logic               pop,
    input logic [CNT_W-1:0]   cnt_now
);
    // R1
    reset_empty_chk: assert property (@(posedge clk)
        !rst_n |=> (!dr_valid && wr_ready && (cnt_now == '0)));

    // R10
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_blk) && $stable(dr_mask)));

    // R5
    room_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_valid && dr_ready) |=> wr_ready);

    // R7
    mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dr_valid |-> (dr_mask != '0));

    // R2
    merge_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && merge_hit && !pop) |=> (cnt_now == $past(cnt_now)));
endmodule

bind merge_wbuf wb_chk #(.BLK_W(BLK_W), .N_WORDS(N_WORDS), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .dr_valid (dr_valid),
    .dr_ready (dr_ready),
    .dr_blk   (dr_blk),
    .dr_mask  (dr_mask),
    .merge_hit(merge_hit),
    .pop      (pop),
    .cnt_now  (cnt_now)
);

// File: tb/sim_merge_wbuf.sv
module sim_merge_wbuf;
    import wb_pkg::*;

    localparam int NE   = WB_ENTRIES;
    localparam int NW   = WB_WORDS;
    localparam int AW   = WB_ADDR_W;
    localparam int DW   = WB_DATA_W;
    localparam int HOLD = WB_HOLD;
    localparam int OFFW = $clog2(NW);
    localparam int BW   = AW - OFFW;

    logic clk = 1'b0;
    always #4 clk = ~clk;  // 125 MHz

    logic              rst_n, merge_en, wr_valid, wr_ready, dr_valid, dr_ready, rc_hit;
    logic [AW-1:0]     wr_addr, rc_addr;
    logic [DW-1:0]     wr_data, rc_data;
    logic [BW-1:0]     dr_blk;
    logic [NW-1:0]     dr_mask;
    logic [NW*DW-1:0]  dr_data;

    merge_wbuf u0 (
        .clk(clk), .rst_n(rst_n), .merge_en(merge_en),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_blk(dr_blk), .dr_mask(dr_mask),
        .dr_data(dr_data), .rc_addr(rc_addr), .rc_hit(rc_hit), .rc_data(rc_data)
    );

    typedef struct packed {
        logic [BW-1:0]          blk;
        logic [NW-1:0]          mask;
        logic [NW-1:0][DW-1:0]  d;
    } ment_t;

    ment_t       q[$];
    int          age;
    int          checks, errors, drains;
    int          drained_blk[$];
    logic [DW-1:0] mem_ref [64];
    logic [DW-1:0] mem_dut [64];
    logic        last_dv, last_rdy, last_rh;
    logic [DW-1:0] last_rd;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // one clock of stimulus, compared against the behavioural model
    task automatic step(input bit wv, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                        input bit drr, input logic [AW-1:0] ra);
        bit            e_dv, e_rdy, e_hit, mhit, acc, pop, touched;
        int            mk, wo, ro;
        logic [BW-1:0] wb, rb;
        logic [DW-1:0] e_rd;
        ment_t         tmp;

        @(negedge clk);
        wr_valid = wv; wr_addr = wa; wr_data = wd; dr_ready = drr; rc_addr = ra;
        #1;
        wb = wa[AW-1:OFFW]; wo = int'(wa[OFFW-1:0]);
        rb = ra[AW-1:OFFW]; ro = int'(ra[OFFW-1:0]);

        e_dv = (q.size() > 0) && ((q[0].mask == '1) || (q.size() > 1) || (age == HOLD));
        mhit = 1'b0; mk = 0;
        if (merge_en)
            for (int k = 0; k < q.size(); k++)
                if (!mhit && q[k].blk == wb && !(k == 0 && e_dv)) begin
                    mhit = 1'b1; mk = k;
                end
        e_rdy = mhit || (q.size() < NE);
        e_hit = 1'b0; e_rd = '0;
        for (int k = q.size() - 1; k >= 0; k--)
            if (!e_hit && q[k].blk == rb && q[k].mask[ro]) begin
                e_hit = 1'b1; e_rd = q[k].d[ro];
            end

        chk(wr_ready == e_rdy, "R5 wr_ready", longint'(wr_ready), longint'(e_rdy));
        chk(dr_valid == e_dv, "R11 dr_valid", longint'(dr_valid), longint'(e_dv));
        if (e_dv) begin
            chk(dr_blk == q[0].blk, "R6 dr_blk", longint'(dr_blk), longint'(q[0].blk));
            chk(dr_mask == q[0].mask, "R7 dr_mask", longint'(dr_mask), longint'(q[0].mask));
            for (int w = 0; w < NW; w++)
                if (q[0].mask[w])
                    chk(dr_data[w*DW +: DW] == q[0].d[w], "R8 dr_data",
                        longint'(dr_data[w*DW +: DW]), longint'(q[0].d[w]));
        end
        chk(rc_hit == e_hit, "R9 rc_hit", longint'(rc_hit), longint'(e_hit));
        if (e_hit)
            chk(rc_data == e_rd, "R9 rc_data", longint'(rc_data), longint'(e_rd));

        last_dv = dr_valid; last_rdy = wr_ready; last_rh = rc_hit; last_rd = rc_data;
        if (dr_valid && dr_ready) begin
            drains++;
            drained_blk.push_back(int'(dr_blk));
            for (int w = 0; w < NW; w++)
                if (dr_mask[w] && (int'(dr_blk) * NW + w) < 64)
                    mem_dut[int'(dr_blk) * NW + w] = dr_data[w*DW +: DW];
        end

        acc = wv && e_rdy;
        pop = e_dv && drr;
        touched = acc && mhit && (mk == 0);
        @(posedge clk);
        if (pop || q.size() == 0 || touched) age = 0;
        else if (age < HOLD) age++;
        if (acc) begin
            mem_ref[int'(wa[5:0])] = wd;
            if (mhit) begin
                tmp = q[mk];
                tmp.mask[wo] = 1'b1;
                tmp.d[wo] = wd;
                q[mk] = tmp;
            end else begin
                tmp = '0;
                tmp.blk = wb;
                tmp.mask[wo] = 1'b1;
                tmp.d[wo] = wd;
                q.push_back(tmp);
            end
        end
        if (pop) void'(q.pop_front());
    endtask

    task automatic idle(input bit drr);
        step(1'b0, '0, '0, drr, '0);
    endtask

    task automatic flush();
        int n = 0;
        while (q.size() > 0 && n < 200) begin
            idle(1'b1);
            n++;
        end
        idle(1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        int d0, lows;
        checks = 0; errors = 0; drains = 0; age = 0;
        for (int i = 0; i < 64; i++) begin mem_ref[i] = '0; mem_dut[i] = '0; end
        rst_n = 1'b0; merge_en = 1'b1; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
        dr_ready = 1'b0; rc_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1
        chk(wr_ready == 1'b1, "R1 wr_ready", longint'(wr_ready), 1);
        chk(dr_valid == 1'b0, "R1 dr_valid", longint'(dr_valid), 0);
        chk(rc_hit == 1'b0, "R1 rc_hit", longint'(rc_hit), 0);

        // R11: lone partial entry waits HOLD cycles
        step(1'b1, AW'(16), 32'hA1, 1'b1, AW'(16));
        lows = 0;
        while (lows < 50) begin
            idle(1'b1);
            if (last_dv) break;
            lows++;
        end
        chk(lows == HOLD, "R11 hold cycles", longint'(lows), longint'(HOLD));
        flush();

        // R2: two words of one block leave together
        d0 = drains;
        step(1'b1, AW'(32), 32'hB0, 1'b1, '0);
        step(1'b1, AW'(34), 32'hB2, 1'b1, '0);
        flush();
        chk(drains - d0 == 1, "R2 one transfer", longint'(drains - d0), 1);

        // R8: same word twice
        step(1'b1, AW'(48), 32'hC0, 1'b1, '0);
        step(1'b1, AW'(48), 32'hC1, 1'b1, '0);
        flush();
        chk(mem_dut[48] == 32'hC1, "R8 last value", longint'(mem_dut[48]), 32'hC1);

        // R4: 16 sequential words, merging on
        d0 = drains;
        for (int i = 0; i < 16; i++) step(1'b1, AW'(i), DW'(32'h100 + i), 1'b1, '0);
        flush();
        chk(drains - d0 == 4, "R4 merged transfers", longint'(drains - d0), 4);

        // R3: same traffic, merging off
        merge_en = 1'b0;
        d0 = drains;
        for (int i = 0; i < 16; i++) step(1'b1, AW'(i), DW'(32'h200 + i), 1'b1, '0);
        flush();
        chk(drains - d0 == 16, "R3 unmerged transfers", longint'(drains - d0), 16);
        merge_en = 1'b1;

        // R5 / R6: fill the buffer and stall
        drained_blk.delete();
        step(1'b1, AW'(0),  32'hD0, 1'b0, '0);
        step(1'b1, AW'(4),  32'hD1, 1'b0, '0);
        step(1'b1, AW'(8),  32'hD2, 1'b0, '0);
        step(1'b1, AW'(12), 32'hD3, 1'b0, '0);
        step(1'b1, AW'(16), 32'hD4, 1'b0, '0);
        chk(last_rdy == 1'b0, "R5 full stall", longint'(last_rdy), 0);
        step(1'b1, AW'(9),  32'hD5, 1'b0, '0);
        chk(last_rdy == 1'b1, "R5 merge while full", longint'(last_rdy), 1);
        step(1'b1, AW'(16), 32'hD4, 1'b1, '0);
        chk(last_rdy == 1'b0, "R5 stall during pop", longint'(last_rdy), 0);
        step(1'b1, AW'(16), 32'hD4, 1'b0, '0);
        chk(last_rdy == 1'b1, "R5 ready after pop", longint'(last_rdy), 1);
        flush();
        chk(drained_blk.size() == 5, "R6 transfer count", longint'(drained_blk.size()), 5);
        for (int i = 0; i < 5 && i < drained_blk.size(); i++)
            chk(drained_blk[i] == i, "R6 order", longint'(drained_blk[i]), longint'(i));

        // R10: offered head refuses a merge
        drained_blk.delete();
        for (int i = 0; i < 4; i++) step(1'b1, AW'(64 + i), DW'(32'hE0 + i), 1'b0, '0);
        step(1'b1, AW'(65), 32'hEF, 1'b0, '0);
        flush();
        chk(drained_blk.size() == 2, "R10 split transfers", longint'(drained_blk.size()), 2);
        for (int i = 0; i < 2 && i < drained_blk.size(); i++)
            chk(drained_blk[i] == 16, "R10 block", longint'(drained_blk[i]), 16);

        // R9: read-check hit and miss
        step(1'b1, AW'(20), 32'hF5, 1'b0, '0);
        idle(1'b0);
        step(1'b0, '0, '0, 1'b0, AW'(20));
        chk(last_rh == 1'b1 && last_rd == 32'hF5, "R9 hit", longint'(last_rd), 32'hF5);
        step(1'b0, '0, '0, 1'b0, AW'(21));
        chk(last_rh == 1'b0, "R9 miss", longint'(last_rh), 0);
        flush();

        // random traffic, both modes
        for (int m = 0; m < 2; m++) begin
            merge_en = (m == 0);
            for (int n = 0; n < 3000; n++)
                step(($urandom_range(0, 9) < 6), AW'($urandom_range(0, 63)), DW'($urandom),
                     ($urandom_range(0, 9) < 7), AW'($urandom_range(0, 63)));
            flush();
        end

        // R12
        for (int i = 0; i < 64; i++)
            chk(mem_dut[i] == mem_ref[i], "R12 memory image",
                longint'(mem_dut[i]), longint'(mem_ref[i]));

        summary();
        $finish;
    end
endmodule